// File: doc/BRIEF.md
# Prioritized Interrupt Sequencer with Single-Step

This block sits beside a simple in-order CPU core and decides, at each instruction boundary, which pending interrupt source is serviced next. The core pulses `insn_done` when an instruction retires. At that edge the block captures the requests tied to the retiring instruction: an instruction exception, a software interrupt and a trace trap. It also captures the level sources (coprocessor segment overrun, and maskable INTR gated by the enable flag). It then issues take-interrupt pulses one per cycle in a fixed priority order. Each pulse carries a vector number and the strobes that ask the core to save flags and return address and to clear its trace and enable flags.

Because the handler of a freshly taken interrupt is entered before it runs any instruction, every further pending source is taken on the very next cycle. The result is a back-to-back chain in which the last source taken is the first one serviced. A non-maskable request is latched on its rising edge and waits for a boundary. A trace trap fires one instruction after the trace flag becomes visible, so the instruction that sets the flag is not itself trapped.

Top module: `irq_sequencer`

## Requirements
- R1: While reset is asserted, and until an instruction boundary follows its release, `take_irq`, `push_req`, `clr_tf`, `clr_if` stay 0 and `irq_vec` is 0, whatever the request inputs do.
- R2: Sources pending at one boundary are taken in the order: exception, single step, NMI, segment overrun, INTR, software INT (highest first).
- R3: A trace trap is raised at a boundary only if `tf` was 1 at the previous boundary; the instruction that completes while `tf` first reads 1 is not trapped.
- R4: The single-step interrupt uses vector 1, and taking any interrupt cancels a pending trace state, so the following instruction with `tf` = 0 is not trapped.
- R5: Every take-interrupt pulse is one cycle long and coincides exactly with `push_req`, `clr_tf` and `clr_if`; none of these strobes is high without `take_irq`.
- R6: After a take, the remaining pending sources are taken in consecutive cycles with no instruction in between. INTR is eligible only as the first take of a chain, because the first take clears the enable flag.
- R7: INTR is ignored at a boundary where `ief` is 0: no take occurs.
- R8: NMI is latched on a rising edge and held until taken at the next boundary, with vector 2; a level held high is taken once only.
- R9: Vectors: exception uses `exc_vec`, software INT uses `swi_vec`, INTR uses `intr_vec`, and segment overrun uses the parameter `SEG_VEC` (default 9). Each is captured at the boundary.
- R10: At most one take pulse per cycle. The first take appears in the second cycle after the clock edge that samples `insn_done`, and no take occurs without a preceding boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | One-cycle strobe: an instruction has completed |
| tf | input | 1 | Live trace flag of the core |
| ief | input | 1 | Live interrupt-enable flag of the core |
| exc_req | input | 1 | Instruction exception from the retiring instruction |
| exc_vec | input | 8 | Vector supplied by the exception source |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| segovr_req | input | 1 | Coprocessor segment-overrun request |
| intr | input | 1 | Maskable interrupt request level |
| intr_vec | input | 8 | Vector supplied for INTR |
| swi_req | input | 1 | Software interrupt request from the retiring instruction |
| swi_vec | input | 8 | Vector supplied with the software interrupt |
| take_irq | output | 1 | Take-interrupt pulse |
| irq_vec | output | 8 | Vector number of the interrupt being taken |
| push_req | output | 1 | Request to save flags and return address |
| clr_tf | output | 1 | Strobe clearing the live trace flag |
| clr_if | output | 1 | Strobe clearing the live enable flag |

## Verification
Single sources are applied alone to confirm each vector. Pairs and larger groups separate a correct priority order from a reversed or shuffled one. A group holding INTR together with other sources shows whether INTR is dropped once the chain has begun. A trace sequence over three instructions tells a trap that fires at once from one delayed by an instruction, and tells whether a take clears the trace state. NMI is driven as a short pulse away from any boundary and then as a held level, which separates edge latching from level sensing and from a single-cycle sample.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int NSRC = 6;
  // priority index: lower index wins
  localparam int S_EXC  = 0;
  localparam int S_STEP = 1;
  localparam int S_NMI  = 2;
  localparam int S_SEG  = 3;
  localparam int S_INTR = 4;
  localparam int S_SWI  = 5;
  localparam int VEC_STEP = 1;
  localparam int VEC_NMI  = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic taken,
  output logic pend
);
  logic lvl_q, pend_q;
  logic lvl_d, pend_d;
  logic rise;

  assign rise = nmi_in & ~lvl_q;

  always_comb begin
    lvl_d  = nmi_in;
    pend_d = (pend_q & ~taken) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R8: a latched request survives until it is taken
  p_nmi_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !taken) |=> pend_q);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int          VW      = 8,
  parameter logic [VW-1:0] SEG_VEC = VW'(9)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          tf,
  input  logic          ief,
  input  logic          exc_req,
  input  logic [VW-1:0] exc_vec,
  input  logic          nmi,
  input  logic          segovr_req,
  input  logic          intr,
  input  logic [VW-1:0] intr_vec,
  input  logic          swi_req,
  input  logic [VW-1:0] swi_vec,
  output logic          take_irq,
  output logic [VW-1:0] irq_vec,
  output logic          push_req,
  output logic          clr_tf,
  output logic          clr_if
);
  logic srst_n;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // sequencing state
  logic            win_q, win_d;        // boundary window open
  logic            chain_q, chain_d;    // a take already happened in window
  logic            tfs_q, tfs_d;        // trace flag seen at previous boundary
  logic [NSRC-1:0] snap_q, snap_d;      // captured boundary requests
  logic [VW-1:0]   excv_q, excv_d;
  logic [VW-1:0]   intv_q, intv_d;
  logic [VW-1:0]   swiv_q, swiv_d;
  logic            take_q, take_d;
  logic [VW-1:0]   vec_q, vec_d;

  logic            boundary;
  logic            st_en;
  logic            nmi_pend;
  logic [NSRC-1:0] req, grant;
  logic            any;
  logic [VW-1:0]   src_vec [NSRC];
  logic [VW-1:0]   sel_vec;

  assign boundary = insn_done & ~win_q;
  assign st_en    = boundary | win_q;

  irq_nmi_edge u_nmi (
    .clk    (clk),
    .rst_n  (srst_n),
    .nmi_in (nmi),
    .taken  (grant[S_NMI]),
    .pend   (nmi_pend)
  );

  always_comb begin
    req         = snap_q;
    req[S_NMI]  = win_q & nmi_pend;
    req[S_INTR] = snap_q[S_INTR] & ~chain_q;
  end

  irq_pick #(.N(NSRC)) u_pick (
    .req   (req),
    .grant (grant),
    .any   (any)
  );

  always_comb begin
    src_vec[S_EXC]  = excv_q;
    src_vec[S_STEP] = VW'(VEC_STEP);
    src_vec[S_NMI]  = VW'(VEC_NMI);
    src_vec[S_SEG]  = SEG_VEC;
    src_vec[S_INTR] = intv_q;
    src_vec[S_SWI]  = swiv_q;
    sel_vec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) sel_vec = sel_vec | src_vec[i];
    end
  end

  // next state
  always_comb begin
    win_d   = win_q;
    chain_d = chain_q;
    tfs_d   = tfs_q;
    snap_d  = snap_q;
    excv_d  = excv_q;
    intv_d  = intv_q;
    swiv_d  = swiv_q;
    take_d  = 1'b0;
    vec_d   = vec_q;
    if (boundary) begin
      win_d          = 1'b1;
      chain_d        = 1'b0;
      tfs_d          = tf;
      snap_d         = '0;
      snap_d[S_EXC]  = exc_req;
      snap_d[S_STEP] = tfs_q;
      snap_d[S_SEG]  = segovr_req;
      snap_d[S_INTR] = intr & ief;
      snap_d[S_SWI]  = swi_req;
      excv_d         = exc_vec;
      intv_d         = intr_vec;
      swiv_d         = swi_vec;
    end else if (win_q) begin
      if (any) begin
        take_d  = 1'b1;
        chain_d = 1'b1;
        tfs_d   = 1'b0;
        snap_d  = snap_q & ~grant;
        vec_d   = sel_vec;
      end else begin
        win_d   = 1'b0;
        chain_d = 1'b0;
        snap_d  = '0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      win_q   <= 1'b0;
      chain_q <= 1'b0;
      tfs_q   <= 1'b0;
      snap_q  <= '0;
      excv_q  <= '0;
      intv_q  <= '0;
      swiv_q  <= '0;
    end else if (st_en) begin
      win_q   <= win_d;
      chain_q <= chain_d;
      tfs_q   <= tfs_d;
      snap_q  <= snap_d;
      excv_q  <= excv_d;
      intv_q  <= intv_d;
      swiv_q  <= swiv_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      vec_q  <= vec_d;
    end
  end

  assign take_irq = take_q;
  assign irq_vec  = vec_q;
  assign push_req = take_q;
  assign clr_tf   = take_q;
  assign clr_if   = take_q;

  // R3: no trace trap unless trace was seen one boundary earlier
  p_trace_delay_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (boundary && !tfs_q) |=> !snap_q[S_STEP]);

  // R7: masked INTR never enters the capture
  p_intr_masked_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (boundary && !ief) |=> !snap_q[S_INTR]);

  // R4: a granted trace trap carries vector 1
  p_step_vec_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (win_q && grant[S_STEP]) |=> (take_q && vec_q == VW'(VEC_STEP)));

  // R10: a take follows every grant, and none happens outside a window
  p_take_after_grant_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (win_q && any) |=> take_q);

  p_quiet_outside_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !win_q |=> !take_q);

  // R6: INTR is never chosen after the chain has started
  p_chain_intr_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (take_q && win_q) |-> !grant[S_INTR]);
endmodule

// File: tb/sim_irq_sequencer.sv
module sim_irq_sequencer;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_done = 1'b0, tf = 1'b0, ief = 1'b0, exc_req = 1'b0;
  logic nmi = 1'b0, segovr_req = 1'b0, intr = 1'b0, swi_req = 1'b0;
  logic [7:0] exc_vec = 8'h0D, intr_vec = 8'h40, swi_vec = 8'h21;
  logic take_irq, push_req, clr_tf, clr_if;
  logic [7:0] irq_vec;

  always #(PERIOD/2) clk = ~clk;

  irq_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .tf(tf), .ief(ief),
    .exc_req(exc_req), .exc_vec(exc_vec), .nmi(nmi), .segovr_req(segovr_req),
    .intr(intr), .intr_vec(intr_vec), .swi_req(swi_req), .swi_vec(swi_vec),
    .take_irq(take_irq), .irq_vec(irq_vec), .push_req(push_req),
    .clr_tf(clr_tf), .clr_if(clr_if)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // collected takes
  int got_n;
  logic [7:0] got [8];
  int got_at [8];
  int strobe_bad;

  task automatic run_insn();
    insn_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    insn_done = 1'b0;
    got_n = 0;
    strobe_bad = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (take_irq !== push_req || take_irq !== clr_tf || take_irq !== clr_if)
        strobe_bad++;
      if (take_irq === 1'b1 && got_n < 8) begin
        got[got_n]    = irq_vec;
        got_at[got_n] = c;
        got_n++;
      end
      if (take_irq === 1'b1) tf = 1'b0;  // core clears its trace flag
    end
  endtask

  typedef struct packed {
    logic       exc;
    logic       swi;
    logic       intr;
    logic       ief;
    logic       seg;
    logic [7:0] first;
    logic [7:0] last;
    logic [3:0] cnt;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0D, 8'h0D, 4'd1},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h21, 8'h21, 4'd1},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h40, 8'h40, 4'd1},
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 4'd0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h09, 8'h09, 4'd1},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0D, 8'h21, 4'd2},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h40, 8'h21, 4'd2},
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h09, 8'h09, 4'd1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0D, 8'h21, 4'd3}
  };

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_seq [5];
    bit ok;
    // R1: idle under reset even with requests and boundaries
    exc_req = 1'b1; swi_req = 1'b1; insn_done = 1'b1; nmi = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(take_irq === 1'b0 && push_req === 1'b0 && clr_tf === 1'b0 &&
          clr_if === 1'b0 && irq_vec === 8'h00, "R1", take_irq, 0);
    end
    insn_done = 1'b0; exc_req = 1'b0; swi_req = 1'b0; nmi = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) @(negedge clk);
    chk(take_irq === 1'b0, "R1 after release", take_irq, 0);

    // table walk: R2 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++) begin
      exc_req = TBL[i].exc; swi_req = TBL[i].swi; intr = TBL[i].intr;
      ief = TBL[i].ief; segovr_req = TBL[i].seg;
      run_insn();
      exc_req = 1'b0; swi_req = 1'b0; intr = 1'b0; ief = 1'b0; segovr_req = 1'b0;
      chk(got_n == int'(TBL[i].cnt), "R2/R6/R7 take count", got_n, TBL[i].cnt);
      chk(strobe_bad == 0, "R5 strobes", strobe_bad, 0);
      if (TBL[i].cnt != 0) begin
        chk(got[0] === TBL[i].first, "R9 first vector", got[0], TBL[i].first);
        chk(got[got_n-1] === TBL[i].last, "R2 last vector", got[got_n-1], TBL[i].last);
        chk(got_at[0] == 0, "R10 latency", got_at[0], 0);
      end
    end

    // R3: first instruction with trace set is not trapped
    tf = 1'b1;
    run_insn();
    chk(got_n == 0, "R3 no early trap", got_n, 0);
    // R4: next instruction traps with vector 1
    run_insn();
    chk(got_n == 1, "R4 trap count", got_n, 1);
    chk(got_n > 0 && got[0] === 8'h01, "R4 trap vector", got[0], 1);
    // R4: trace cleared by the take, so following instruction is clean
    run_insn();
    chk(got_n == 0, "R4 trace cancelled", got_n, 0);

    // R8: short NMI pulse away from a boundary waits
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    ok = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (take_irq !== 1'b0) ok = 1'b0;
    end
    chk(ok, "R8 waits for boundary", take_irq, 0);
    run_insn();
    chk(got_n == 1 && got[0] === 8'h02, "R8 latched nmi", got[0], 2);
    // R8: held level taken once
    nmi = 1'b1; @(negedge clk);
    run_insn();
    chk(got_n == 1 && got[0] === 8'h02, "R8 level first", got[0], 2);
    run_insn();
    chk(got_n == 0, "R8 level not retaken", got_n, 0);
    nmi = 1'b0;

    // R2 R6: full chain with trace, nmi, exc, seg, intr, swi
    tf = 1'b1;
    run_insn();
    chk(got_n == 0, "R3 arm trace", got_n, 0);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    exc_req = 1'b1; segovr_req = 1'b1; intr = 1'b1; ief = 1'b1; swi_req = 1'b1;
    run_insn();
    exc_req = 1'b0; segovr_req = 1'b0; intr = 1'b0; ief = 1'b0; swi_req = 1'b0;
    exp_seq = '{8'h0D, 8'h01, 8'h02, 8'h09, 8'h21};
    chk(got_n == 5, "R6 chain length", got_n, 5);
    for (int k = 0; k < 5; k++) begin
      if (k < got_n) begin
        chk(got[k] === exp_seq[k], "R2 chain order", got[k], exp_seq[k]);
        chk(got_at[k] == k, "R6 back-to-back", got_at[k], k);
      end
    end
    chk(strobe_bad == 0, "R5 chain strobes", strobe_bad, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule